// File: doc/BRIEF.md
# Input Capture Channel Front End

This block is the input side of one timer capture channel. It picks one of two asynchronous pins, brings that pin into the clock domain, and removes short glitches with a programmable-length filter. It then turns the cleaned level into a single qualified edge event of the chosen polarity. That one event is used in two ways. It is sent on as a one-clock trigger pulse for a slave-mode controller. It is also the capture command, which first passes through an edge prescaler.

When the prescaler lets an edge through, the block stores the running counter value in an internal shadow stage. On the next clock the value moves into the software-visible capture register and the capture flag is raised. If that flag was still set when the new value arrived, an overcapture flag is raised as well. A single clear input drops both flags. The counter itself and the compare and output stage sit outside this block.

Top module: `icap_channel`

## Requirements
- R1: The selected pin passes through a 2-stage synchronizer and a filter. The filtered level follows the synchronized level only once the synchronized level has held a new value for `filt_len`+1 consecutive clocks. A pulse that lasts `filt_len` clocks or fewer produces no edge.
- R2: A qualified edge drives `trig_out` high for exactly one clock. For a pin change driven just before clock edge 0, `trig_out` is high in the cycle after clock edge `filt_len`+3.
- R3: `pol_sel` sets which edges qualify: 2'b00 qualifies rising edges only, 2'b01 falling edges only, and 2'b10 or 2'b11 both.
- R4: `src_sel` picks the input: 2'b01 takes `pin_own` and 2'b10 takes `pin_alt`. With 2'b00 or 2'b11 the channel is inactive and makes neither triggers nor captures. The pin that is not selected has no effect.
- R5: Every qualified edge on an active channel produces a trigger pulse, whatever the values of `psc_sel` and `cap_en`.
- R6: A capture takes place on every 1st, 2nd, 4th or 8th qualified edge, for `psc_sel` = 0, 1, 2 or 3. The edge count restarts from zero whenever capture is off, which is when `cap_en` is 0 or the channel is inactive. With capture off, no capture takes place.
- R7: On a capture, `cap_val` takes the `cnt_val` that was present in the clock cycle just before `trig_out` rose. The new value appears one clock after `trig_out` rises. At all other times `cap_val` holds its value.
- R8: `cap_flag` rises in the same clock as `cap_val` updates and stays high until a `flag_clr` pulse.
- R9: `ovr_flag` is set when a capture arrives while `cap_flag` is still set. `flag_clr` clears it.
- R10: During and directly after reset, `trig_out`, `cap_val`, `cap_flag` and `ovr_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_own | input | 1 | Asynchronous channel pin |
| pin_alt | input | 1 | Asynchronous pin of the neighbouring channel |
| src_sel | input | 2 | Input source select |
| pol_sel | input | 2 | Edge polarity select |
| filt_len | input | FILT_W (4) | Filter length in clocks, minus one |
| psc_sel | input | PSC_W (2) | Capture prescaler exponent |
| cap_en | input | 1 | Capture enable |
| flag_clr | input | 1 | Clears the capture and overcapture flags |
| cnt_val | input | CNT_W (16) | Running counter value |
| trig_out | output | 1 | One-clock trigger pulse per qualified edge |
| cap_val | output | CNT_W (16) | Software-visible capture register |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |

## Verification
The assertions check on every cycle that triggers appear only when a valid source is selected and that `cap_val` changes only just after a trigger. They also check that the capture flag rises only after a trigger, that the overcapture flag rises only while the capture flag is set, and that a clear with no capture pending empties both flags. Other behaviours can only be shown by the bench's scenarios: the exact trigger latency, glitch rejection at the filter boundary, the polarity choices, the prescaler ratios and their restart, and the captured counter values.

// File: rtl/icap_pkg.sv
// Package: shared encodings for the input capture channel.
// Assumes: 2-bit source and polarity selects.
package icap_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_OWN  = 2'b01,
        SRC_ALT  = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        POL_RISE  = 2'b00,
        POL_FALL  = 2'b01,
        POL_ANY   = 2'b10,
        POL_ANY_B = 2'b11
    } pol_e;

    // True when the source select routes a real pin into the channel.
    function automatic logic src_active(input logic [1:0] sel);
        return (sel == SRC_OWN) || (sel == SRC_ALT);
    endfunction

    // True when rising edges qualify under the polarity select.
    function automatic logic pol_takes_rise(input logic [1:0] sel);
        return (sel == POL_RISE) || sel[1];
    endfunction

    // True when falling edges qualify under the polarity select.
    function automatic logic pol_takes_fall(input logic [1:0] sel);
        return (sel == POL_FALL) || sel[1];
    endfunction

endpackage

// File: rtl/icap_input_filter.sv
// Module: icap_input_filter
// Brings an asynchronous pin into the clock domain through a synchronizer
// chain, then passes a level change only after it has held for
// filt_len+1 consecutive clocks.
// Assumes: SYNC_STAGES >= 1; filt_len is static while the input is active.
module icap_input_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_async,
    input  logic [FILT_W-1:0] filt_len,
    output logic              filt_lvl
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_lvl;
    logic [FILT_W-1:0]      run_q;
    logic                   lvl_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            // Single-stage capture of the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_async;
            end
        end else begin : g_sync_chain
            // Shift the pin through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign sync_lvl = sync_q[SYNC_STAGES-1];

    // Count consecutive disagreeing samples; adopt the new level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            lvl_q <= 1'b0;
        end else if (sync_lvl == lvl_q) begin
            run_q <= '0;
        end else if (run_q >= filt_len) begin
            lvl_q <= sync_lvl;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign filt_lvl = lvl_q;

endmodule

// File: rtl/icap_edge_qual.sv
// Module: icap_edge_qual
// Detects edges of the filtered level, keeps those that match the polarity
// select, and registers them into a one-clock trigger pulse.
// Assumes: filt_lvl is already synchronous to clk.
module icap_edge_qual
    import icap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       filt_lvl,
    input  logic [1:0] pol_sel,
    input  logic       active,
    output logic       edge_hit,
    output logic       trig_pulse
);

    logic prev_q;
    logic rise_w;
    logic fall_w;

    // Remember the previous filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= filt_lvl;
    end

    assign rise_w   = filt_lvl & ~prev_q;
    assign fall_w   = ~filt_lvl & prev_q;
    assign edge_hit = active & ((rise_w & pol_takes_rise(pol_sel)) |
                                (fall_w & pol_takes_fall(pol_sel)));

    // Register the qualified edge as the trigger output.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_pulse <= 1'b0;
        else        trig_pulse <= edge_hit;
    end

endmodule

// File: rtl/icap_edge_prescaler.sv
// Module: icap_edge_prescaler
// Lets through one of every 2**psc_sel qualified edges as a capture command.
// The edge count restarts whenever capture is off.
// Assumes: psc_sel changes only while capture is off.
module icap_edge_prescaler #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_hit,
    input  logic             cap_on,
    input  logic [PSC_W-1:0] psc_sel,
    output logic             cap_fire
);

    localparam int CNT_BITS = (2 ** PSC_W) - 1;

    logic [CNT_BITS-1:0] cnt_q;
    logic [CNT_BITS-1:0] limit;

    // Build the terminal count 2**psc_sel - 1 as a thermometer mask.
    always_comb begin
        for (int i = 0; i < CNT_BITS; i++) begin
            limit[i] = (i < int'(psc_sel));
        end
    end

    assign cap_fire = edge_hit & cap_on & (cnt_q >= limit);

    // Advance the edge count, wrapping on a capture, clearing while off.
    always_ff @(posedge clk) begin
        if (!rst_n || !cap_on) cnt_q <= '0;
        else if (cap_fire)     cnt_q <= '0;
        else if (edge_hit)     cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/icap_capture_store.sv
// Module: icap_capture_store
// Holds the counter in a shadow stage on a capture command. On the next clock
// it moves the value into the visible register and updates the flags.
// Assumes: cnt_val is synchronous to clk.
module icap_capture_store #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_fire,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);

    logic [CNT_W-1:0] shadow_q;
    logic             xfer_q;

    // Latch the counter into the shadow stage on a capture command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            xfer_q   <= 1'b0;
        end else begin
            xfer_q <= cap_fire;
            if (cap_fire) shadow_q <= cnt_val;
        end
    end

    // Move the shadow value into the visible register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_val <= '0;
        else if (xfer_q) cap_val <= shadow_q;
    end

    // Update the capture and overcapture flags; a transfer beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_flag <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            if (xfer_q)        cap_flag <= 1'b1;
            else if (flag_clr) cap_flag <= 1'b0;

            if (xfer_q && cap_flag && !flag_clr) ovr_flag <= 1'b1;
            else if (flag_clr)                   ovr_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/icap_channel.sv
// Module: icap_channel (top)
// Input capture channel front end: source select, synchronizer and filter,
// polarity edge qualifier, trigger output, edge prescaler and shadowed capture.
// Assumes: configuration changes only while the selected pin is quiet.
module icap_channel
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int FILT_W      = 4,
    parameter int PSC_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_own,
    input  logic              pin_alt,
    input  logic [1:0]        src_sel,
    input  logic [1:0]        pol_sel,
    input  logic [FILT_W-1:0] filt_len,
    input  logic [PSC_W-1:0]  psc_sel,
    input  logic              cap_en,
    input  logic              flag_clr,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic              trig_out,
    output logic [CNT_W-1:0]  cap_val,
    output logic              cap_flag,
    output logic              ovr_flag
);

    logic sel_pin;
    logic active;
    logic cap_on;
    logic filt_lvl;
    logic edge_hit;
    logic cap_fire;

    // Route the chosen pin; an inactive source reads as constant low.
    always_comb begin
        unique case (src_sel)
            SRC_OWN: sel_pin = pin_own;
            SRC_ALT: sel_pin = pin_alt;
            default: sel_pin = 1'b0;
        endcase
    end

    assign active = src_active(src_sel);
    assign cap_on = cap_en & active;

    icap_input_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_W      (FILT_W)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (sel_pin),
        .filt_len  (filt_len),
        .filt_lvl  (filt_lvl)
    );

    icap_edge_qual u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_lvl   (filt_lvl),
        .pol_sel    (pol_sel),
        .active     (active),
        .edge_hit   (edge_hit),
        .trig_pulse (trig_out)
    );

    icap_edge_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .cap_on   (cap_on),
        .psc_sel  (psc_sel),
        .cap_fire (cap_fire)
    );

    icap_capture_store #(
        .CNT_W (CNT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_fire (cap_fire),
        .cnt_val  (cnt_val),
        .flag_clr (flag_clr),
        .cap_val  (cap_val),
        .cap_flag (cap_flag),
        .ovr_flag (ovr_flag)
    );

endmodule

// File: rtl/icap_channel_chk.sv
// Module: icap_channel_chk
// Property checker for icap_channel, attached through bind.
// Assumes: synchronous active-low reset on rst_n.
module icap_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       src_sel,
    input logic             flag_clr,
    input logic             trig_out,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag,
    input logic             ovr_flag
);

    // A trigger needs a valid source in the cycle before it.
    assert_trig_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> ($past(src_sel) == 2'b01 || $past(src_sel) == 2'b10));

    // The capture register changes only right after a trigger pulse.
    assert_capval_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val) |-> $past(trig_out));

    // The capture flag rises only right after a trigger pulse.
    assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> $past(trig_out));

    // A clear with no capture in flight empties both flags.
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !trig_out) |=> (!cap_flag && !ovr_flag));

    // Overcapture rises only while the capture flag was already set.
    assert_ovr_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(cap_flag));

endmodule

bind icap_channel icap_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .flag_clr (flag_clr),
    .trig_out (trig_out),
    .cap_val  (cap_val),
    .cap_flag (cap_flag),
    .ovr_flag (ovr_flag)
);

// File: tb/icap_channel_tb.sv
module icap_channel_tb;

    localparam int CNT_W  = 16;
    localparam int FILT_W = 4;
    localparam int PSC_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              pin_own, pin_alt;
    logic [1:0]        src_sel, pol_sel;
    logic [FILT_W-1:0] filt_len;
    logic [PSC_W-1:0]  psc_sel;
    logic              cap_en, flag_clr;
    logic [CNT_W-1:0]  cnt_val;
    logic              trig_out, cap_flag, ovr_flag;
    logic [CNT_W-1:0]  cap_val;

    int unsigned cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    int trig_seen = 0;
    int cap_seen = 0;
    int last_trig_cyc = 0;
    bit pend = 0;
    logic [CNT_W-1:0] exp_val = '0;
    bit m_flag = 0;
    bit m_ovr = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign cnt_val = cyc[CNT_W-1:0];

    icap_channel #(.CNT_W(CNT_W), .FILT_W(FILT_W), .PSC_W(PSC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_own(pin_own), .pin_alt(pin_alt),
        .src_sel(src_sel), .pol_sel(pol_sel), .filt_len(filt_len),
        .psc_sel(psc_sel), .cap_en(cap_en), .flag_clr(flag_clr),
        .cnt_val(cnt_val), .trig_out(trig_out), .cap_val(cap_val),
        .cap_flag(cap_flag), .ovr_flag(ovr_flag)
    );

    function automatic bit src_on(input logic [1:0] s);
        return (s == 2'b01) || (s == 2'b10);
    endfunction

    function automatic int edges_per_pulse(input logic [1:0] p);
        return ((p == 2'b00 || p[1]) ? 1 : 0) + ((p == 2'b01 || p[1]) ? 1 : 0);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model: watches triggers, predicts captures and flags (R6..R9).
    always begin
        @(posedge clk);
        #2;
        if (rst_n) begin
            if (pend) begin
                pend = 0;
                cap_seen++;
                m_ovr = m_ovr | m_flag;
                m_flag = 1;
                chk("R7 cap_val", cap_val, exp_val);
                chk("R8 cap_flag", cap_flag, 1);
                chk("R9 ovr_flag", ovr_flag, m_ovr);
            end
            if (!(cap_en && src_on(src_sel))) m_cnt = 0;
            if (trig_out) begin
                trig_seen++;
                last_trig_cyc = cyc;
                if (cap_en && src_on(src_sel)) begin
                    if (m_cnt == (1 << psc_sel) - 1) begin
                        pend = 1;
                        exp_val = cnt_val - 1'b1;
                        m_cnt = 0;
                    end else begin
                        m_cnt++;
                    end
                end
            end
        end
    end

    task automatic cfg(input logic [1:0] s, input logic [1:0] p, input int f,
                       input int ps, input bit en);
        @(negedge clk);
        cap_en = 0; pin_own = 0; pin_alt = 0;
        repeat (20) @(negedge clk);
        src_sel = s; pol_sel = p; filt_len = FILT_W'(f); psc_sel = PSC_W'(ps);
        repeat (4) @(negedge clk);
        cap_en = en;
        @(negedge clk);
    endtask

    task automatic drive(input bit alt, input bit val, input int hold);
        @(negedge clk);
        if (alt) pin_alt = val; else pin_own = val;
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic pulse(input bit alt, input int hi, input int lo);
        drive(alt, 1, hi);
        drive(alt, 0, lo);
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        m_flag = 0; m_ovr = 0;
        chk("R8 cap_flag after clear", cap_flag, 0);
        chk("R9 ovr_flag after clear", ovr_flag, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0, k0, c0;
        logic [CNT_W-1:0] hold_val;
        void'($urandom(32'd4021));
        rst_n = 0; pin_own = 0; pin_alt = 0; src_sel = 2'b01; pol_sel = 0;
        filt_len = 0; psc_sel = 0; cap_en = 0; flag_clr = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 trig_out", trig_out, 0);
        chk("R10 cap_val", cap_val, 0);
        chk("R10 cap_flag", cap_flag, 0);
        chk("R10 ovr_flag", ovr_flag, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R10 cap_flag after release", cap_flag, 0);

        // R2 latency and single pulse, R3 rising only
        for (int f = 0; f <= 3; f += 3) begin
            cfg(2'b01, 2'b00, f, 0, 1);
            @(negedge clk); pin_own = 1; c0 = cyc; t0 = trig_seen;
            repeat (f + 10) @(negedge clk);
            chk("R2 one pulse per edge", trig_seen - t0, 1);
            chk("R2 latency", last_trig_cyc - c0, f + 4);
            @(negedge clk); pin_own = 0; t0 = trig_seen;
            repeat (f + 10) @(negedge clk);
            chk("R3 falling ignored in rising mode", trig_seen - t0, 0);
        end

        // R1 glitch rejection at the filter boundary
        cfg(2'b01, 2'b10, 5, 0, 0);
        t0 = trig_seen;
        pulse(0, 5, 20);
        chk("R1 short pulse rejected", trig_seen - t0, 0);
        t0 = trig_seen;
        pulse(0, 6, 20);
        chk("R1 long pulse passes both edges", trig_seen - t0, 2);

        // R3 falling polarity
        cfg(2'b01, 2'b01, 2, 0, 0);
        t0 = trig_seen;
        drive(0, 1, 12);
        chk("R3 rising ignored in falling mode", trig_seen - t0, 0);
        @(negedge clk); pin_own = 0; c0 = cyc;
        repeat (12) @(negedge clk);
        chk("R3 falling edge triggers", trig_seen - t0, 1);
        chk("R3 falling latency", last_trig_cyc - c0, 6);

        // R4 source select
        cfg(2'b01, 2'b00, 1, 0, 1);
        t0 = trig_seen; k0 = cap_seen;
        pulse(1, 6, 10);
        chk("R4 alt pin ignored when own selected", trig_seen - t0, 0);
        chk("R4 no capture from alt pin", cap_seen - k0, 0);
        cfg(2'b10, 2'b00, 1, 0, 1);
        t0 = trig_seen; k0 = cap_seen;
        pulse(0, 6, 10);
        chk("R4 own pin ignored when alt selected", trig_seen - t0, 0);
        pulse(1, 6, 10);
        chk("R4 alt pin triggers", trig_seen - t0, 1);
        chk("R4 alt pin captures", cap_seen - k0, 1);
        for (int s = 0; s < 4; s += 3) begin
            cfg(2'(s), 2'b10, 1, 0, 1);
            hold_val = cap_val; t0 = trig_seen;
            pulse(0, 6, 10);
            pulse(1, 6, 10);
            chk("R4 inactive source no trigger", trig_seen - t0, 0);
            chk("R4 inactive source holds cap_val", cap_val, hold_val);
        end

        // R5 and R6 prescaler ratio
        cfg(2'b01, 2'b00, 1, 2, 1);
        t0 = trig_seen; k0 = cap_seen;
        for (int i = 0; i < 8; i++) pulse(0, 6, 6);
        repeat (10) @(negedge clk);
        chk("R5 every edge triggers with prescaler", trig_seen - t0, 8);
        chk("R6 divide by 4", cap_seen - k0, 2);
        cfg(2'b01, 2'b00, 1, 3, 0);
        t0 = trig_seen; k0 = cap_seen;
        for (int i = 0; i < 3; i++) pulse(0, 6, 6);
        repeat (10) @(negedge clk);
        chk("R5 triggers with capture disabled", trig_seen - t0, 3);
        chk("R6 no capture when disabled", cap_seen - k0, 0);

        // R6 count restart on disable
        cfg(2'b01, 2'b00, 1, 2, 1);
        k0 = cap_seen;
        pulse(0, 6, 6); pulse(0, 6, 6);
        @(negedge clk); cap_en = 0;
        repeat (5) @(negedge clk); cap_en = 1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) pulse(0, 6, 6);
        repeat (10) @(negedge clk);
        chk("R6 count restarted after disable", cap_seen - k0, 0);
        pulse(0, 6, 10);
        chk("R6 fourth edge after restart captures", cap_seen - k0, 1);

        // R8 and R9 flags
        clear_flags();
        cfg(2'b01, 2'b00, 1, 0, 1);
        pulse(0, 6, 10);
        chk("R8 flag set by capture", cap_flag, 1);
        chk("R9 no overcapture on first", ovr_flag, 0);
        hold_val = cap_val;
        pulse(0, 6, 10);
        chk("R9 overcapture set", ovr_flag, 1);
        hold_val = cap_val;
        clear_flags();
        repeat (5) @(negedge clk);
        chk("R7 cap_val holds without capture", cap_val, hold_val);

        // Random bursts against the reference model
        for (int b = 0; b < 150; b++) begin
            logic [1:0] s, p;
            int f, ps, n, expt;
            bit en, alt;
            s = 2'($urandom % 4); p = 2'($urandom % 4);
            f = $urandom % 8; ps = $urandom % 4; en = 1'($urandom % 2);
            alt = (s == 2'b10);
            cfg(s, p, f, ps, en);
            t0 = trig_seen; k0 = cap_seen;
            n = 1 + $urandom % 6;
            expt = 0;
            for (int i = 0; i < n; i++) begin
                for (int lv = 1; lv >= 0; lv--) begin
                    @(negedge clk);
                    if (alt) begin pin_alt = 1'(lv); pin_own = 1'($urandom % 2); end
                    else     begin pin_own = 1'(lv); pin_alt = 1'($urandom % 2); end
                    repeat (f + 1 + $urandom % 5) @(negedge clk);
                end
                if (src_on(s)) expt += edges_per_pulse(p);
            end
            repeat (f + 8) @(negedge clk);
            chk("R5 random trigger count", trig_seen - t0, expt);
            chk("R6 random capture count", cap_seen - k0,
                (en && src_on(s)) ? expt / (1 << ps) : 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule